// File: doc/BRIEF.md
# Serial Transceiver with Automatic Request/Clear-to-Send Handshake

This block is a full-duplex asynchronous serial port that runs on one system clock. A programmable divisor produces a tick at sixteen times the bit rate. A transmitter serialises bytes from a 16-entry transmit queue. A receiver oversamples the incoming line and stores each completed character, together with a framing-error bit, in a 16-entry receive queue. The host side loads the transmit queue and drains the receive queue through plain valid/ready ports. Both queue occupancies are visible as level outputs.

Two active-low handshake lines pace the traffic without software involvement. The request-to-send output tells the remote end to stop once the receive queue reaches a programmable threshold. It stays in that state until the queue has been emptied completely, so the peer sees a hysteresis window rather than rapid toggling. The clear-to-send input is resynchronised and checked before every character starts. A character that has already begun always finishes.

Top module: `uart_fc`

## Requirements
- R1: After reset, rts_n is 0, ser_tx is 1, tx_level and rx_level are 0, tx_ready is 1, rx_valid is 0 and overrun is 0.
- R2: Each transmitted character is one low start bit, then eight data bits with the least significant bit first, then one high stop bit. Every bit lasts 16 × divisor clock cycles, and the line rests high between characters.
- R3: The transmit queue holds 16 bytes and sends them in the order they were accepted. tx_ready is 0 while it is full, a push offered while full is discarded, and tx_level reports the occupancy.
- R4: No character starts while cts_n, seen through a two-stage synchroniser, is 1. A character already under way when cts_n rises is completed, and no further character starts until cts_n falls again.
- R5: Received characters are delivered on rx_data in arrival order, with rx_valid high while the receive queue is non-empty. A pop (rx_valid and rx_ready at a clock edge) removes one entry, and rx_level reports the occupancy.
- R6: A low pulse on ser_rx that has ended before the middle of the would-be start bit (8 ticks after detection) is ignored and stores nothing.
- R7: A character whose stop bit is sampled low is stored with rx_frame_err = 1 and its data intact. Reception then resumes once the line returns high, and later good characters carry rx_frame_err = 0.
- R8: A character that completes while the receive queue is full is discarded, and overrun is set to 1. overrun stays 1 until reset.
- R9: rts_n rises to 1 within two cycles of rx_level reaching the threshold. The threshold is rts_thresh, with 0 treated as 1 and values above 16 treated as 16.
- R10: Once rts_n is 1 it stays 1 while rx_level is non-zero, and it returns to 0 only after rx_level reaches 0.
- R11: A divisor of 0 behaves exactly like a divisor of 1, giving 16 clock cycles per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| divisor | input | 16 | Clock cycles per oversample tick (0 acts as 1) |
| rts_thresh | input | 5 | Receive level at which rts_n is raised |
| tx_data | input | 8 | Byte to queue for transmission |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmit queue can accept a byte |
| tx_level | output | 5 | Transmit queue occupancy |
| rx_data | output | 8 | Oldest received byte |
| rx_frame_err | output | 1 | Oldest received byte had a low stop bit |
| rx_valid | output | 1 | Receive queue holds at least one entry |
| rx_ready | input | 1 | Host removes the oldest entry |
| rx_level | output | 5 | Receive queue occupancy |
| overrun | output | 1 | Sticky: a character was dropped because the queue was full |
| ser_tx | output | 1 | Serial transmit line |
| ser_rx | input | 1 | Serial receive line (asynchronous) |
| cts_n | input | 1 | Peer clear-to-send, active low (asynchronous) |
| rts_n | output | 1 | Request-to-send to peer, active low |

## Verification
The embedded assertions watch several invariants on every cycle. The transmit line rests high when idle. A frame leaves the idle state only if the synchronised clear-to-send was low. rts_n rises only at or above the threshold and never falls while received data remain. Queue occupancy never exceeds its depth, overrun never clears, and a character is never written into a full receive queue. Other properties need whole frames and can only be shown by the bench scenarios. These are bit order and bit duration, including a divisor of 0, and the completion of a frame interrupted by clear-to-send. They also include glitch rejection, the framing-error flag and recovery after it, the exact item dropped on overrun, and the full hysteresis cycle of request-to-send.

// File: rtl/uart_fc_pkg.sv
// Shared constants and state encodings for the flow-controlled serial port.
// Assumes 8-bit characters with one start and one stop bit.
package uart_fc_pkg;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned OVERSAMPLE = 16;
    localparam int unsigned OS_W       = $clog2(OVERSAMPLE);
    localparam int unsigned BIT_W      = $clog2(DATA_W);
    localparam logic [OS_W-1:0] OS_LAST = OS_W'(OVERSAMPLE - 1);
    localparam logic [OS_W-1:0] OS_MID  = OS_W'(OVERSAMPLE / 2 - 1);

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rx_state_e;
endpackage

// File: rtl/uart_fc_baud.sv
// Oversample tick generator: a down-counter that reloads on terminal count
// and emits one tick every max(divisor,1) cycles.
// Assumes divisor changes only while both serial directions are idle.
module uart_fc_baud #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] eff_div;
    logic [DIV_W-1:0] cnt_q;

    // Zero divisor is promoted to one.
    assign eff_div = (divisor == '0) ? DIV_W'(1) : divisor;
    assign tick    = (cnt_q == '0);

    // Count down, reload on terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= eff_div - DIV_W'(1);
        else           cnt_q <= cnt_q - DIV_W'(1);
    end

    // Ticks are spaced by the divisor: never back to back unless divisor <= 1.
    p_tick_spacing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && eff_div > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/uart_fc_fifo.sv
// Synchronous first-in first-out queue with level output.
// Assumes DEPTH is a power of two; pushes when full and pops when empty are ignored.
module uart_fc_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             din,
    input  logic                         pop,
    output logic [WIDTH-1:0]             dout,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic             do_push, do_pop;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_q];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            level <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + AW'(1);
            if (do_pop)  rd_q <= rd_q + AW'(1);
            case ({do_push, do_pop})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
    p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
endmodule

// File: rtl/uart_fc_tx.sv
// Transmit serialiser: start bit, 8 data bits LSB first, stop bit, each 16 ticks.
// A character starts only on a tick with queued data and synchronised clear-to-send low.
// Assumes has_data/data come from a queue whose head is stable until popped.
module uart_fc_tx
    import uart_fc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cts_n,
    input  logic              has_data,
    input  logic [DATA_W-1:0] data,
    output logic              pop,
    output logic              ser_tx
);
    tx_state_e         state_q;
    logic [OS_W-1:0]   os_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] sh_q;
    logic              cts_meta_q, cts_s_q;

    // Two-stage synchroniser for the asynchronous clear-to-send input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_meta_q <= 1'b1;
            cts_s_q    <= 1'b1;
        end else begin
            cts_meta_q <= cts_n;
            cts_s_q    <= cts_meta_q;
        end
    end

    assign pop = (state_q == TX_IDLE) && tick && has_data && !cts_s_q;

    // Frame sequencer and registered line driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            os_q    <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            ser_tx  <= 1'b1;
        end else begin
            case (state_q)
                TX_IDLE: if (pop) begin
                    state_q <= TX_START;
                    sh_q    <= data;
                    os_q    <= '0;
                    bit_q   <= '0;
                    ser_tx  <= 1'b0;
                end
                TX_START: if (tick) begin
                    os_q <= os_q + OS_W'(1);
                    if (os_q == OS_LAST) begin
                        state_q <= TX_DATA;
                        ser_tx  <= sh_q[0];
                    end
                end
                TX_DATA: if (tick) begin
                    os_q <= os_q + OS_W'(1);
                    if (os_q == OS_LAST) begin
                        if (bit_q == BIT_W'(DATA_W - 1)) begin
                            state_q <= TX_STOP;
                            ser_tx  <= 1'b1;
                        end else begin
                            bit_q  <= bit_q + BIT_W'(1);
                            sh_q   <= sh_q >> 1;
                            ser_tx <= sh_q[1];
                        end
                    end
                end
                TX_STOP: if (tick) begin
                    os_q <= os_q + OS_W'(1);
                    if (os_q == OS_LAST) state_q <= TX_IDLE;
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    p_line_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE || state_q == TX_STOP) |-> ser_tx);
    p_start_needs_cts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_START && $past(state_q) == TX_IDLE) |-> !$past(cts_s_q));
endmodule

// File: rtl/uart_fc_rx.sv
// Receive deserialiser with 16x oversampling and mid-bit sampling.
// Rejects start bits that are high at mid-bit, flags low stop bits, drops
// characters when the queue is full (sticky overrun), and after a low stop
// bit waits for the line to return high before hunting for a new start.
module uart_fc_rx
    import uart_fc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ser_rx,
    input  logic              full,
    output logic              push,
    output logic [DATA_W-1:0] data,
    output logic              ferr,
    output logic              overrun
);
    rx_state_e         state_q;
    logic [OS_W-1:0]   os_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] sh_q;
    logic              rx_meta_q, rx_s_q;

    // Two-stage synchroniser for the asynchronous serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_meta_q <= 1'b1;
            rx_s_q    <= 1'b1;
        end else begin
            rx_meta_q <= ser_rx;
            rx_s_q    <= rx_meta_q;
        end
    end

    // Frame sequencer, data capture and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            os_q    <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            push    <= 1'b0;
            data    <= '0;
            ferr    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            push <= 1'b0;
            case (state_q)
                RX_IDLE: if (tick && !rx_s_q) begin
                    state_q <= RX_START;
                    os_q    <= '0;
                end
                RX_START: if (tick) begin
                    if (os_q == OS_MID) begin
                        os_q    <= '0;
                        bit_q   <= '0;
                        state_q <= rx_s_q ? RX_IDLE : RX_DATA;
                    end else begin
                        os_q <= os_q + OS_W'(1);
                    end
                end
                RX_DATA: if (tick) begin
                    os_q <= os_q + OS_W'(1);
                    if (os_q == OS_LAST) begin
                        sh_q <= {rx_s_q, sh_q[DATA_W-1:1]};
                        if (bit_q == BIT_W'(DATA_W - 1)) state_q <= RX_STOP;
                        else bit_q <= bit_q + BIT_W'(1);
                    end
                end
                RX_STOP: if (tick) begin
                    os_q <= os_q + OS_W'(1);
                    if (os_q == OS_LAST) begin
                        if (full) begin
                            overrun <= 1'b1;
                        end else begin
                            push <= 1'b1;
                            data <= sh_q;
                            ferr <= !rx_s_q;
                        end
                        state_q <= rx_s_q ? RX_IDLE : RX_HOLD;
                    end
                end
                RX_HOLD: if (rx_s_q) state_q <= RX_IDLE;
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
endmodule

// File: rtl/uart_fc.sv
// Top level of the flow-controlled serial port: tick generator, two queues,
// serialiser, deserialiser and the request-to-send hysteresis register.
// Assumes FIFO_DEPTH is a power of two and rts_thresh changes only when quiet.
module uart_fc
    import uart_fc_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned DIV_W      = 16,
    parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [LVL_W-1:0]  rts_thresh,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [LVL_W-1:0]  tx_level,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_frame_err,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [LVL_W-1:0]  rx_level,
    output logic              overrun,
    output logic              ser_tx,
    input  logic              ser_rx,
    input  logic              cts_n,
    output logic              rts_n
);
    logic              tick;
    logic              tx_full, tx_empty, tx_pop;
    logic [DATA_W-1:0] tx_head;
    logic              rx_full, rx_empty, rx_push, rx_ferr;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W:0]   rx_head;
    logic [LVL_W-1:0]  thr_eff;

    uart_fc_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
    );

    uart_fc_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_valid), .din(tx_data),
        .pop(tx_pop), .dout(tx_head),
        .full(tx_full), .empty(tx_empty), .level(tx_level)
    );

    uart_fc_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cts_n(cts_n),
        .has_data(!tx_empty), .data(tx_head), .pop(tx_pop), .ser_tx(ser_tx)
    );

    uart_fc_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ser_rx(ser_rx), .full(rx_full),
        .push(rx_push), .data(rx_byte), .ferr(rx_ferr), .overrun(overrun)
    );

    uart_fc_fifo #(.WIDTH(DATA_W + 1), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din({rx_ferr, rx_byte}),
        .pop(rx_ready), .dout(rx_head),
        .full(rx_full), .empty(rx_empty), .level(rx_level)
    );

    assign tx_ready     = !tx_full;
    assign rx_valid     = !rx_empty;
    assign rx_data      = rx_head[DATA_W-1:0];
    assign rx_frame_err = rx_head[DATA_W];

    // Clamp the threshold into 1..FIFO_DEPTH.
    assign thr_eff = (rts_thresh == '0)                ? LVL_W'(1) :
                     (rts_thresh > LVL_W'(FIFO_DEPTH)) ? LVL_W'(FIFO_DEPTH) : rts_thresh;

    // Hysteresis: raise at threshold, release only when fully drained.
    always_ff @(posedge clk) begin
        if (!rst_n)     rts_n <= 1'b0;
        else if (rts_n) rts_n <= (rx_level != '0);
        else            rts_n <= (rx_level >= thr_eff);
    end

    p_rts_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts_n) |-> $past(rx_level >= thr_eff));
    p_rts_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_n && rx_level != '0) |=> rts_n);
endmodule

// File: tb/uart_fc_bench.sv
module uart_fc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] divisor = 16'd2;
    logic [4:0]  rts_thresh = 5'd16;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [4:0]  tx_level;
    logic [7:0]  rx_data;
    logic        rx_frame_err;
    logic        rx_valid;
    logic        rx_ready = 1'b0;
    logic [4:0]  rx_level;
    logic        overrun;
    logic        ser_tx;
    logic        ser_rx = 1'b1;
    logic        cts_n = 1'b0;
    logic        rts_n;

    int checks = 0;
    int errors = 0;
    int bitc   = 32;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    uart_fc u_uart_fc (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .rts_thresh(rts_thresh),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_level(tx_level),
        .rx_data(rx_data), .rx_frame_err(rx_frame_err), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_level(rx_level), .overrun(overrun),
        .ser_tx(ser_tx), .ser_rx(ser_rx), .cts_n(cts_n), .rts_n(rts_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Peer transmitter model: start, 8 data LSB first, stop (value given), one idle bit.
    task automatic send_byte(input logic [7:0] b, input logic stopv);
        ser_rx = 1'b0;
        wait_n(bitc);
        for (int i = 0; i < 8; i++) begin
            ser_rx = b[i];
            wait_n(bitc);
        end
        ser_rx = stopv;
        wait_n(bitc);
        ser_rx = 1'b1;
        wait_n(bitc);
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_valid = 1'b1;
        tx_data  = b;
        wait_n(1);
        tx_valid = 1'b0;
    endtask

    task automatic pop_rx(output logic [7:0] d, output logic fe, output logic ok);
        ok = rx_valid;
        d  = rx_data;
        fe = rx_frame_err;
        rx_ready = 1'b1;
        wait_n(1);
        rx_ready = 1'b0;
    endtask

    // Peer receiver model: find the start edge, sample at mid-bit, compare.
    task automatic capture_tx(input logic [7:0] exp, input int raise_at, input string req);
        int t = 0;
        logic [7:0] got = 8'h00;
        while (ser_tx && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 20000, req, t, 0);
        wait_n(bitc / 2);
        chk(ser_tx == 1'b0, req, int'(ser_tx), 0);
        for (int i = 0; i < 8; i++) begin
            wait_n(bitc);
            got[i] = ser_tx;
            if (i == raise_at) cts_n = 1'b1;
        end
        chk(got == exp, req, int'(got), int'(exp));
        wait_n(bitc);
        chk(ser_tx == 1'b1, req, int'(ser_tx), 1);
    endtask

    // Count cycles where the transmit line is low over a window.
    task automatic quiet_tx(input int n, input string req);
        int lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!ser_tx) lows++;
        end
        chk(lows == 0, req, lows, 0);
    endtask

    logic [7:0] txq [16];
    logic [7:0] rxq [17];
    logic [7:0] d;
    logic       fe, ok;

    initial begin
        void'($urandom(32'h5EED_0042));
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        // R1 reset state
        chk(rts_n == 1'b0, "R1 rts_n", int'(rts_n), 0);
        chk(ser_tx == 1'b1, "R1 ser_tx", int'(ser_tx), 1);
        chk(tx_level == 5'd0 && rx_level == 5'd0, "R1 levels", int'(tx_level) + int'(rx_level), 0);
        chk(tx_ready && !rx_valid && !overrun, "R1 flags",
            int'({tx_ready, rx_valid, overrun}), 4);

        // R11 + R2: divisor 0 acts as 1 -> 16 cycles per bit
        divisor = 16'd0;
        bitc = 16;
        push_tx(8'hA5);
        capture_tx(8'hA5, -1, "R11 divisor0 frame");
        divisor = 16'd2;
        bitc = 32;
        wait_n(bitc);
        push_tx(8'h3E);
        capture_tx(8'h3E, -1, "R2 frame div2");

        // R3/R4: fill queue while blocked by clear-to-send
        cts_n = 1'b1;
        wait_n(4);
        for (int i = 0; i < 16; i++) begin
            txq[i] = 8'($urandom);
            push_tx(txq[i]);
        end
        chk(tx_ready == 1'b0, "R3 ready low when full", int'(tx_ready), 0);
        chk(tx_level == 5'd16, "R3 level full", int'(tx_level), 16);
        push_tx(8'hFF);
        wait_n(3);
        chk(tx_level == 5'd16, "R3 push when full ignored", int'(tx_level), 16);
        quiet_tx(3 * 10 * bitc, "R4 no start while cts high");
        cts_n = 1'b0;
        capture_tx(txq[0], 3, "R4 frame completes after cts rises");
        quiet_tx(3 * 10 * bitc, "R4 held after in-flight frame");
        chk(tx_level == 5'd15, "R4 level after one frame", int'(tx_level), 15);
        cts_n = 1'b0;
        for (int i = 1; i < 16; i++) capture_tx(txq[i], -1, "R3 order");
        quiet_tx(2 * 10 * bitc, "R3 dropped push never sent");
        chk(tx_level == 5'd0, "R3 drained", int'(tx_level), 0);

        // R5: random receive stream
        rts_thresh = 5'd16;
        for (int i = 0; i < 8; i++) begin
            rxq[i] = 8'($urandom);
            send_byte(rxq[i], 1'b1);
        end
        chk(rx_level == 5'd8, "R5 level", int'(rx_level), 8);
        for (int i = 0; i < 8; i++) begin
            pop_rx(d, fe, ok);
            chk(ok && d == rxq[i] && !fe, "R5 data", int'(d), int'(rxq[i]));
        end
        chk(!rx_valid, "R5 empty after pops", int'(rx_valid), 0);

        // R6: short low pulse rejected
        ser_rx = 1'b0;
        wait_n(3 * 2);
        ser_rx = 1'b1;
        wait_n(12 * bitc);
        chk(rx_level == 5'd0, "R6 glitch ignored", int'(rx_level), 0);

        // R7: framing error then recovery
        send_byte(8'h3C, 1'b0);
        wait_n(bitc);
        chk(rx_level == 5'd1, "R7 stored", int'(rx_level), 1);
        pop_rx(d, fe, ok);
        chk(ok && d == 8'h3C, "R7 data", int'(d), 'h3C);
        chk(fe == 1'b1, "R7 flag set", int'(fe), 1);
        send_byte(8'h5A, 1'b1);
        pop_rx(d, fe, ok);
        chk(ok && d == 8'h5A && fe == 1'b0, "R7 recovery", int'({fe, d}), 'h05A);

        // R9/R10: threshold 4 and hysteresis
        rts_thresh = 5'd4;
        for (int i = 0; i < 3; i++) send_byte(8'(8'h10 + i), 1'b1);
        chk(rts_n == 1'b0, "R9 below threshold", int'(rts_n), 0);
        send_byte(8'h13, 1'b1);
        chk(rts_n == 1'b1, "R9 at threshold", int'(rts_n), 1);
        pop_rx(d, fe, ok);
        wait_n(3);
        chk(rts_n == 1'b1, "R10 held at level 3", int'(rts_n), 1);
        pop_rx(d, fe, ok);
        pop_rx(d, fe, ok);
        wait_n(3);
        chk(rts_n == 1'b1, "R10 held at level 1", int'(rts_n), 1);
        pop_rx(d, fe, ok);
        wait_n(3);
        chk(rts_n == 1'b0, "R10 released when empty", int'(rts_n), 0);

        // R9 clamp: threshold 0 acts as 1
        rts_thresh = 5'd0;
        send_byte(8'h77, 1'b1);
        chk(rts_n == 1'b1, "R9 threshold 0 as 1", int'(rts_n), 1);
        pop_rx(d, fe, ok);
        wait_n(3);
        chk(rts_n == 1'b0, "R10 release after single", int'(rts_n), 0);

        // R8: overrun with a 17th character
        rts_thresh = 5'd16;
        chk(overrun == 1'b0, "R8 clear before", int'(overrun), 0);
        for (int i = 0; i < 17; i++) begin
            rxq[i] = 8'($urandom);
            send_byte(rxq[i], 1'b1);
        end
        chk(rx_level == 5'd16, "R8 level capped", int'(rx_level), 16);
        chk(overrun == 1'b1, "R8 flag set", int'(overrun), 1);
        chk(rts_n == 1'b1, "R9 at 16", int'(rts_n), 1);
        for (int i = 0; i < 16; i++) begin
            pop_rx(d, fe, ok);
            chk(ok && d == rxq[i], "R8 kept oldest", int'(d), int'(rxq[i]));
        end
        wait_n(3);
        chk(!rx_valid, "R8 17th dropped", int'(rx_valid), 0);
        chk(overrun == 1'b1, "R8 sticky", int'(overrun), 1);
        chk(rts_n == 1'b0, "R10 release after drain", int'(rts_n), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule